// File: doc/BRIEF.md
# Instruction-Cycle Micro-Operation Sequencer

This block is the hardwired control unit and datapath of a small accumulator machine. Its registers are a program counter, a memory address register, a memory buffer register, an instruction register and one data register. A 2-bit cycle code names the current phase: fetch, indirect, execute or interrupt. A step counter inside each phase picks one micro-operation for each clock. A decoder turns the pair (cycle code, step), together with the opcode, into register-transfer and memory-strobe controls.

Memory is reached through a single synchronous port with an address, write data, read data, a read strobe and a write strobe. Read data must be valid in the same cycle as the read strobe. An instruction is 16 bits wide. Bits 15:13 hold the opcode, bit 12 is the indirect flag, and bits 11:0 hold the address. A single interrupt request is latched. It is acted on at the end of an instruction by saving the PC to a fixed save address and jumping to a fixed service address.

Top module: `icyc_seq`

## Requirements
- R1: While rst_ni is low, and right after it rises, the PC, the data register, the MAR and the MBR read zero, the cycle code is 00, and neither memory strobe is asserted.
- R2: Fetch takes three clocks. Step 0 sets the address to the PC. Step 1 asserts the read strobe, captures the read data into the MBR and increments the PC. Step 2 moves the MBR into the IR.
- R3: cyc_code_o encodes the phase as 00 fetch, 01 indirect, 10 execute and 11 interrupt. It changes only after the last step of a phase.
- R4: Indirect takes three clocks. The address is set to IR[11:0]. Memory is then read into the MBR. Finally IR[11:0] is replaced by MBR[11:0], so execute then uses the fetched pointer.
- R5: Opcode 001 (ADD) takes three execute clocks: address from IR, memory read into the MBR, then the data register takes its old value plus the MBR, modulo 2^16.
- R6: Opcode 011 (LOAD) takes three execute clocks: address from IR, memory read, then the data register takes the MBR.
- R7: Opcode 010 (ISZ) takes four execute clocks: address from IR, memory read, MBR incremented, then MBR written back. The PC also increments in the write-back step when the written value is zero.
- R8: Every other opcode spends a single execute clock with no strobe and no register change.
- R9: After fetch comes indirect when bit 12 of the fetched word is set, and execute otherwise. Indirect always leads to execute. Interrupt always leads to fetch.
- R10: Interrupt takes three clocks. First the MBR takes the PC. Next the MAR takes SAVE_ADDR and the PC takes ISR_ADDR. Last the MBR is written to memory.
- R11: A high irq_i is held as pending until the interrupt phase begins. Execute leads to interrupt only when the request was already pending before the last execute clock. irq_i is ignored during the interrupt phase.
- R12: No clock asserts the read strobe together with an IR load, and no clock asserts both read and write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request |
| mem_addr_o | output | ADDR_W | Memory address (MAR) |
| mem_wdata_o | output | DATA_W | Memory write data (MBR) |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the strobe cycle |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| cyc_code_o | output | 2 | Current instruction-cycle code |
| pc_o | output | ADDR_W | Program counter |
| r1_o | output | DATA_W | Data register |

## Verification
Two pairs of functions can land on the same clock. The ISZ write-back and the conditional skip of the PC share one step. An interrupt request can also arrive on the final execute step, or while the interrupt phase is already running. The program therefore has ISZ on operands that wrap to zero and on operands that do not. It raises irq_i at fixed cycles and again during every interrupt phase within a window. A behavioural model in the bench predicts the strobes, the address, the write data, the PC, the data register and the cycle code for every clock. It decides whether a late or in-phase request is deferred or dropped.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IND   = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_INT   = 2'b11
  } cyc_e;

  localparam int unsigned OP_W   = 3;
  localparam int unsigned STEP_W = 2;

  localparam logic [OP_W-1:0] OP_ADD  = 3'b001;
  localparam logic [OP_W-1:0] OP_ISZ  = 3'b010;
  localparam logic [OP_W-1:0] OP_LOAD = 3'b011;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_from_save;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic mbr_inc;
    logic ir_from_mbr;
    logic ir_addr_from_mbr;
    logic pc_inc;
    logic pc_from_isr;
    logic pc_skip_zero;
    logic r1_add;
    logic r1_load;
    logic mem_rd;
    logic mem_wr;
    logic last;
  } ctrl_t;

endpackage

// File: rtl/icyc_timing.sv
module icyc_timing
  import icyc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              ind_i,
  input  logic              irq_i,
  output cyc_e              cyc_o,
  output logic [STEP_W-1:0] step_o,
  output logic              pend_o
);

  cyc_e              cyc_q, cyc_d;
  logic [STEP_W-1:0] step_q;
  logic              pend_q;

  always_comb begin
    cyc_d = cyc_q;
    if (last_i) begin
      unique case (cyc_q)
        CYC_FETCH: cyc_d = ind_i ? CYC_IND : CYC_EXEC;
        CYC_IND:   cyc_d = CYC_EXEC;
        CYC_EXEC:  cyc_d = pend_q ? CYC_INT : CYC_FETCH;
        CYC_INT:   cyc_d = CYC_FETCH;
        default:   cyc_d = CYC_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_FETCH;
      step_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      step_q <= last_i ? '0 : step_q + 1'b1;
    end
  end

  // request held until interrupt phase; masked while it runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_q <= 1'b0;
    else if (cyc_q == CYC_INT) pend_q <= 1'b0;
    else if (irq_i)            pend_q <= 1'b1;
  end

  assign cyc_o  = cyc_q;
  assign step_o = step_q;
  assign pend_o = pend_q;

  AST_FETCH_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_FETCH && last_i) |=> (cyc_q == CYC_IND || cyc_q == CYC_EXEC)); // R9
  AST_INT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_INT && last_i) |=> (cyc_q == CYC_FETCH && step_q == '0)); // R9
  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> ($stable(cyc_q) && step_q == STEP_W'($past(step_q) + 1'b1))); // R3
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_INT) |=> !pend_q); // R11

endmodule

// File: rtl/icyc_ctrl_dec.sv
module icyc_ctrl_dec
  import icyc_pkg::*;
(
  input  cyc_e              cyc_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [OP_W-1:0]   op_i,
  output ctrl_t             ctrl_o
);

  logic mem_op;
  assign mem_op = (op_i == OP_ADD) || (op_i == OP_ISZ) || (op_i == OP_LOAD);

  always_comb begin
    ctrl_o = '0;
    unique case (cyc_i)
      CYC_FETCH: begin
        unique case (step_i)
          2'd0: ctrl_o.mar_from_pc = 1'b1;
          2'd1: begin
            ctrl_o.mem_rd       = 1'b1;
            ctrl_o.mbr_from_mem = 1'b1;
            ctrl_o.pc_inc       = 1'b1;
          end
          default: begin
            ctrl_o.ir_from_mbr = 1'b1;
            ctrl_o.last        = 1'b1;
          end
        endcase
      end
      CYC_IND: begin
        unique case (step_i)
          2'd0: ctrl_o.mar_from_ir = 1'b1;
          2'd1: begin
            ctrl_o.mem_rd       = 1'b1;
            ctrl_o.mbr_from_mem = 1'b1;
          end
          default: begin
            ctrl_o.ir_addr_from_mbr = 1'b1;
            ctrl_o.last             = 1'b1;
          end
        endcase
      end
      CYC_EXEC: begin
        if (!mem_op) begin
          ctrl_o.last = 1'b1;
        end else begin
          unique case (step_i)
            2'd0: ctrl_o.mar_from_ir = 1'b1;
            2'd1: begin
              ctrl_o.mem_rd       = 1'b1;
              ctrl_o.mbr_from_mem = 1'b1;
            end
            2'd2: begin
              if (op_i == OP_ISZ) begin
                ctrl_o.mbr_inc = 1'b1;
              end else begin
                ctrl_o.r1_add  = (op_i == OP_ADD);
                ctrl_o.r1_load = (op_i == OP_LOAD);
                ctrl_o.last    = 1'b1;
              end
            end
            default: begin
              ctrl_o.mem_wr       = 1'b1;
              ctrl_o.pc_skip_zero = 1'b1;
              ctrl_o.last         = 1'b1;
            end
          endcase
        end
      end
      default: begin
        unique case (step_i)
          2'd0: ctrl_o.mbr_from_pc = 1'b1;
          2'd1: begin
            ctrl_o.mar_from_save = 1'b1;
            ctrl_o.pc_from_isr   = 1'b1;
          end
          default: begin
            ctrl_o.mem_wr = 1'b1;
            ctrl_o.last   = 1'b1;
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/icyc_datapath.sv
module icyc_datapath
  import icyc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'hFF0,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] r1_o
);

  logic [ADDR_W-1:0] mar_q, pc_q;
  logic [DATA_W-1:0] mbr_q, ir_q, r1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
    end else if (ctrl_i.mar_from_pc) begin
      mar_q <= pc_q;
    end else if (ctrl_i.mar_from_ir) begin
      mar_q <= ir_q[ADDR_W-1:0];
    end else if (ctrl_i.mar_from_save) begin
      mar_q <= SAVE_ADDR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbr_q <= '0;
    end else if (ctrl_i.mbr_from_mem) begin
      mbr_q <= rdata_i;
    end else if (ctrl_i.mbr_from_pc) begin
      mbr_q <= DATA_W'(pc_q);
    end else if (ctrl_i.mbr_inc) begin
      mbr_q <= mbr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0;
    end else if (ctrl_i.ir_from_mbr) begin
      ir_q <= mbr_q;
    end else if (ctrl_i.ir_addr_from_mbr) begin
      ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (ctrl_i.pc_from_isr) begin
      pc_q <= ISR_ADDR;
    end else if (ctrl_i.pc_inc || (ctrl_i.pc_skip_zero && mbr_q == '0)) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q <= '0;
    end else if (ctrl_i.r1_add) begin
      r1_q <= r1_q + mbr_q;
    end else if (ctrl_i.r1_load) begin
      r1_q <= mbr_q;
    end
  end

  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;
  assign pc_o  = pc_q;
  assign r1_o  = r1_q;

  AST_RD_NOT_IR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.mem_rd |-> !(ctrl_i.ir_from_mbr || ctrl_i.ir_addr_from_mbr)); // R12
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.pc_inc |=> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R2
  AST_ISR_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.pc_from_isr |=> (pc_q == ISR_ADDR && mar_q == SAVE_ADDR)); // R10

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
  import icyc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'hFF0,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [1:0]        cyc_code_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] r1_o
);

  localparam int unsigned IND_BIT = ADDR_W;
  localparam int unsigned OP_LSB  = ADDR_W + 1;

  cyc_e              cyc;
  logic [STEP_W-1:0] step;
  logic              pend;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] mbr, ir;

  icyc_timing u_timing (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_i (ctrl.last),
    .ind_i  (mbr[IND_BIT]),
    .irq_i  (irq_i),
    .cyc_o  (cyc),
    .step_o (step),
    .pend_o (pend)
  );

  icyc_ctrl_dec u_dec (
    .cyc_i  (cyc),
    .step_i (step),
    .op_i   (ir[OP_LSB +: OP_W]),
    .ctrl_o (ctrl)
  );

  icyc_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
  ) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_i  (ctrl),
    .rdata_i (mem_rdata_i),
    .mar_o   (mem_addr_o),
    .mbr_o   (mbr),
    .ir_o    (ir),
    .pc_o    (pc_o),
    .r1_o    (r1_o)
  );

  assign mem_wdata_o = mbr;
  assign mem_rd_o    = ctrl.mem_rd;
  assign mem_wr_o    = ctrl.mem_wr;
  assign cyc_code_o  = cyc;

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R12
  AST_EXEC_TO_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_EXEC && ctrl.last && pend) |=> cyc == CYC_INT); // R11

endmodule

// File: tb/icyc_seq_tb_top.sv
module icyc_seq_tb_top;

  localparam logic [11:0] SAVE_A = 12'hFF0;
  localparam logic [11:0] ISR_A  = 12'h100;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        irq;
  logic [11:0] addr;
  logic [15:0] wdata, rdata;
  logic        rd, wr;
  logic [1:0]  cyc;
  logic [11:0] pc;
  logic [15:0] r1;

  always #5 clk = ~clk;

  logic [15:0] mem [0:4095];
  assign rdata = mem[addr];

  icyc_seq #(.SAVE_ADDR(SAVE_A), .ISR_ADDR(ISR_A)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .mem_rd_o(rd), .mem_wr_o(wr), .cyc_code_o(cyc), .pc_o(pc), .r1_o(r1)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  logic [1:0]  m_ph;
  int          m_st;
  logic [11:0] m_pc, m_mar;
  logic [15:0] m_mbr, m_ir, m_r1;
  bit          m_pend;

  function automatic string tag_of(input logic [1:0] ph, input logic [2:0] op);
    case (ph)
      2'b00: return "R2";
      2'b01: return "R4";
      2'b11: return "R10";
      default: case (op)
        3'b001: return "R5";
        3'b011: return "R6";
        3'b010: return "R7";
        default: return "R8";
      endcase
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    mem[12'h000] = 16'h6200; // LOAD 200
    mem[12'h001] = 16'h3201; // ADD @201
    mem[12'h002] = 16'h4203; // ISZ 203 -> wraps, skip
    mem[12'h003] = 16'h2200; // skipped
    mem[12'h004] = 16'h4204; // ISZ 204 -> no skip
    mem[12'h005] = 16'h0000; // idle
    mem[12'h006] = 16'h2205; // ADD wrap
    mem[12'h007] = 16'h5206; // ISZ @206 -> skip
    mem[12'h008] = 16'h2200; // skipped
    mem[12'h009] = 16'hE000; // idle opcode 111
    mem[12'h00A] = 16'h2200;
    mem[12'h100] = 16'h6202; // service: LOAD 202
    mem[12'h101] = 16'h2204;
    mem[12'h200] = 16'h0005;
    mem[12'h201] = 16'h0202;
    mem[12'h202] = 16'h0007;
    mem[12'h203] = 16'hFFFF;
    mem[12'h204] = 16'h0003;
    mem[12'h205] = 16'hFFFF;
    mem[12'h206] = 16'h0207;
    mem[12'h207] = 16'hFFFF;

    rst_ni = 1'b0;
    irq    = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 pc", 32'(pc), 0);
    chk("R1 cyc", 32'(cyc), 0);
    rst_ni = 1'b1;
    chk("R1 r1", 32'(r1), 0);
    chk("R1 addr", 32'(addr), 0);
    chk("R1 wdata", 32'(wdata), 0);
    chk("R1 strobes", {30'd0, rd, wr}, 0);

    m_ph = 2'b00; m_st = 0; m_pc = '0; m_mar = '0;
    m_mbr = '0; m_ir = '0; m_r1 = '0; m_pend = 1'b0;

    for (int n = 0; n < 900; n++) begin
      logic [2:0] op;
      bit         e_rd, e_wr, last, memop, irq_v;
      logic [1:0] nxt;
      string      t;
      op    = m_ir[15:13];
      memop = (op == 3'b001) || (op == 3'b010) || (op == 3'b011);
      e_rd  = (m_st == 1) && ((m_ph != 2'b11 && m_ph != 2'b10) || (m_ph == 2'b10 && memop));
      e_wr  = (m_ph == 2'b10 && op == 3'b010 && m_st == 3) || (m_ph == 2'b11 && m_st == 2);
      t     = tag_of(m_ph, op);

      chk({t, " rd"},    32'(rd), 32'(e_rd));
      chk({t, " wr"},    32'(wr), 32'(e_wr));
      chk({t, " addr"},  32'(addr), 32'(m_mar));
      chk({t, " wdata"}, 32'(wdata), 32'(m_mbr));
      chk({t, " pc"},    32'(pc), 32'(m_pc));
      chk({t, " r1"},    32'(r1), 32'(m_r1));
      chk((m_ph == 2'b11) ? "R11 cyc" : "R3 R9 cyc", 32'(cyc), 32'(m_ph));
      chk("R12 rd/wr", 32'(rd && wr), 0);

      // request pattern: fixed pulses plus pulses inside interrupt phases
      irq_v = (n == 30) || (n == 31) || (n == 75) ||
              (m_ph == 2'b11 && n > 90 && n < 260) || (n == 300);
      irq   = irq_v;

      last = 1'b0;
      nxt  = m_ph;
      case (m_ph)
        2'b00: case (m_st)
          0: m_mar = m_pc;
          1: begin m_mbr = mem[m_mar]; m_pc = m_pc + 1'b1; end
          default: begin
            m_ir = m_mbr; last = 1'b1;
            nxt = m_mbr[12] ? 2'b01 : 2'b10;
          end
        endcase
        2'b01: case (m_st)
          0: m_mar = m_ir[11:0];
          1: m_mbr = mem[m_mar];
          default: begin m_ir[11:0] = m_mbr[11:0]; last = 1'b1; nxt = 2'b10; end
        endcase
        2'b10: begin
          if (!memop) last = 1'b1;
          else case (m_st)
            0: m_mar = m_ir[11:0];
            1: m_mbr = mem[m_mar];
            2: begin
              if (op == 3'b010) m_mbr = m_mbr + 1'b1;
              else begin
                if (op == 3'b001) m_r1 = m_r1 + m_mbr;
                else m_r1 = m_mbr;
                last = 1'b1;
              end
            end
            default: begin
              mem[m_mar] = m_mbr;
              if (m_mbr == 16'h0000) m_pc = m_pc + 1'b1;
              last = 1'b1;
            end
          endcase
          if (last) nxt = m_pend ? 2'b11 : 2'b00;
        end
        default: case (m_st)
          0: m_mbr = {4'h0, m_pc};
          1: begin m_mar = SAVE_A; m_pc = ISR_A; end
          default: begin mem[m_mar] = m_mbr; last = 1'b1; nxt = 2'b00; end
        endcase
      endcase
      if (m_ph == 2'b11) m_pend = 1'b0;
      else if (irq_v)    m_pend = 1'b1;
      m_st = last ? 0 : m_st + 1;
      m_ph = nxt;
      @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule